// File: doc/BRIEF.md
# Context-Decision Pair Sequencer

This block sits between a column-parallel context modeler and a serial arithmetic coder. The modeler can produce up to ten context/decision pairs in one clock. Each pair has a 5-bit context and a 1-bit decision, and each slot has its own valid flag. The coder can take only one pair per clock. The sequencer removes the empty slots from each burst and closes the gaps without changing the slot order. It stores the surviving pairs in a circular queue and presents them one at a time in the same order.

The slot index carries the scan order. The modeler places the four samples of a column in row order, top to bottom. Within a sample it places the zero-coding or run-length pair before the sign pair. Successive columns arrive as successive beats, left to right. Sending the pairs out in slot order and then beat order therefore keeps the scan order intact.

Both edges use valid/ready. On the input side a beat is taken when `in_valid` and `in_ready` are both high. `in_ready` depends only on the queue occupancy: it is high when at least `SLOTS` entries are free. So a beat is always taken whole, or not at all. On the output side a pair leaves when `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the payload does not change. The `clear` input empties the queue at the start of each code block.

Top module: `cxd_sequencer`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: In an accepted beat, slots whose valid bit is 0 are dropped. The remaining pairs are queued in rising slot index: slot 0 goes first, and within a slot the context is bits [5i+4:5i] of `in_cx` and the decision is bit i of `in_dec`.
- R3: `out_valid` is high exactly when the queue holds at least one pair. While `out_ready` stays high, one pair leaves on every clock.
- R4: While `out_valid` is high and `out_ready` is low, `out_cx` and `out_dec` keep their values on the next clock.
- R5: `in_ready` is 1 exactly when at least `SLOTS` queue entries are free. A beat presented while `in_ready` is 0 is not queued.
- R6: Every valid pair of an accepted beat is queued in that same clock, and the occupancy never exceeds `DEPTH`.
- R7: A cycle with `clear` high empties the queue. The beat and the pop of that cycle are discarded, so on the next clock `out_valid` is 0 and `in_ready` is 1.
- R8: Output order equals acceptance order. This holds across wrap of the circular storage and when a full ten-pair beat is taken while the output is stalled.
- R9: A beat can be accepted in the same clock as a pair is popped, and the occupancy then changes by the number of pushed pairs minus one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous queue flush at code-block start |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Room for a whole beat |
| in_slot_vld | input | SLOTS | Per-slot valid flags |
| in_cx | input | SLOTS*CX_W | Slot contexts, slot i at bits [CX_W*i +: CX_W] |
| in_dec | input | SLOTS | Slot decisions |
| out_valid | output | 1 | Output pair valid |
| out_ready | input | 1 | Coder accepts a pair |
| out_cx | output | CX_W | Output context |
| out_dec | output | 1 | Output decision |

## Verification
The bench uses ten slots and a 16-entry queue. With these values a single full beat leaves fewer than ten entries free, so `in_ready` toggles on almost every beat and the write pointer wraps every few beats. Every one of the 1024 slot-valid masks is pushed once with the output free-running and once under a pseudo-random `out_ready` pattern. A model queue in the bench predicts the payload, `out_valid` and `in_ready` on every clock. Separate phases fill the queue behind a stalled output, present beats while it is full, and issue `clear` in the same cycle as a beat.

// File: rtl/cxd_pkg.sv
package cxd_pkg;
  localparam int CX_W = 5;

  typedef struct packed {
    logic [CX_W-1:0] cx;
    logic            dec;
  } cxd_pair_t;
endpackage

// File: rtl/cxd_compact.sv
module cxd_compact
  import cxd_pkg::*;
#(
  parameter int SLOTS = 10,
  localparam int CNT_W = $clog2(SLOTS + 1)
) (
  input  logic [SLOTS-1:0]      slot_vld,
  input  logic [SLOTS*CX_W-1:0] slot_cx,
  input  logic [SLOTS-1:0]      slot_dec,
  output cxd_pair_t             packed_pairs [SLOTS],
  output logic [CNT_W-1:0]      packed_n
);
  cxd_pair_t slot_pair [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_unpack
    assign slot_pair[g].cx  = slot_cx[g*CX_W +: CX_W];
    assign slot_pair[g].dec = slot_dec[g];
  end

  always_comb begin
    logic [CNT_W-1:0] pos;
    pos = '0;
    for (int i = 0; i < SLOTS; i++) packed_pairs[i] = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (slot_vld[i]) begin
        packed_pairs[pos] = slot_pair[i];
        pos = pos + CNT_W'(1);
      end
    end
    packed_n = pos;
  end
endmodule

// File: rtl/cxd_queue.sv
module cxd_queue
  import cxd_pkg::*;
#(
  parameter int SLOTS = 10,
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int OCC_W = $clog2(DEPTH + 1),
  localparam int CNT_W = $clog2(SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  cxd_pair_t        din [SLOTS],
  input  logic [CNT_W-1:0] din_n,
  output logic             room,
  input  logic             pop,
  output logic             nonempty,
  output cxd_pair_t        dout
);
  cxd_pair_t        mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [OCC_W-1:0] occ;
  logic [OCC_W-1:0] free_n;
  logic [OCC_W-1:0] add_n;
  logic [OCC_W-1:0] sub_n;

  assign free_n   = OCC_W'(DEPTH) - occ;
  assign room     = free_n >= OCC_W'(SLOTS);
  assign nonempty = occ != '0;
  assign dout     = mem[rd_ptr];
  assign add_n    = push ? OCC_W'(din_n) : '0;
  assign sub_n    = pop  ? OCC_W'(1)     : '0;

  always_ff @(posedge clk) begin
    if (push && !flush) begin
      for (int k = 0; k < SLOTS; k++) begin
        if (CNT_W'(k) < din_n) mem[wr_ptr + PTR_W'(k)] <= din[k];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      wr_ptr <= wr_ptr + PTR_W'(add_n);
      rd_ptr <= rd_ptr + PTR_W'(sub_n);
      occ    <= occ + add_n - sub_n;
    end
  end
endmodule

// File: rtl/cxd_sequencer.sv
module cxd_sequencer
  import cxd_pkg::*;
#(
  parameter int SLOTS = 10,
  parameter int DEPTH = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clear,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [SLOTS-1:0]      in_slot_vld,
  input  logic [SLOTS*CX_W-1:0] in_cx,
  input  logic [SLOTS-1:0]      in_dec,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [CX_W-1:0]       out_cx,
  output logic                  out_dec
);
  localparam int CNT_W = $clog2(SLOTS + 1);

  cxd_pair_t        packed_pairs [SLOTS];
  logic [CNT_W-1:0] packed_n;
  cxd_pair_t        head;
  logic             push, pop;

  cxd_compact #(.SLOTS(SLOTS)) u_compact (
    .slot_vld     (in_slot_vld),
    .slot_cx      (in_cx),
    .slot_dec     (in_dec),
    .packed_pairs (packed_pairs),
    .packed_n     (packed_n)
  );

  assign push = in_valid && in_ready;
  assign pop  = out_valid && out_ready;

  cxd_queue #(.SLOTS(SLOTS), .DEPTH(DEPTH)) u_queue (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (clear),
    .push     (push),
    .din      (packed_pairs),
    .din_n    (packed_n),
    .room     (in_ready),
    .pop      (pop),
    .nonempty (out_valid),
    .dout     (head)
  );

  assign out_cx  = head.cx;
  assign out_dec = head.dec;
endmodule

// File: rtl/cxd_sequencer_checker.sv
module cxd_sequencer_checker #(
  parameter int SLOTS = 10,
  parameter int DEPTH = 16,
  parameter int CX_W  = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clear,
  input logic             in_valid,
  input logic             in_ready,
  input logic [SLOTS-1:0] in_slot_vld,
  input logic             out_valid,
  input logic             out_ready,
  input logic [CX_W-1:0]  out_cx,
  input logic             out_dec
);
  int occ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ <= 0;
    else if (clear) occ <= 0;
    else occ <= occ + ((in_valid && in_ready) ? int'($countones(in_slot_vld)) : 0)
                    - ((out_valid && out_ready) ? 1 : 0);
  end

  p_ready_rule_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == ((DEPTH - occ) >= SLOTS));
  p_valid_nonempty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == (occ != 0));
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= DEPTH);
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !clear) |=> (out_valid && $stable(out_cx) && $stable(out_dec)));
  p_clear_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!out_valid && in_ready));
endmodule

bind cxd_sequencer cxd_sequencer_checker #(.SLOTS(SLOTS), .DEPTH(DEPTH), .CX_W(cxd_pkg::CX_W)) u_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .clear       (clear),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_slot_vld (in_slot_vld),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_cx      (out_cx),
  .out_dec     (out_dec)
);

// File: tb/cxd_sequencer_test.sv
module cxd_sequencer_test;
  localparam int CLK_PERIOD = 10;
  localparam int SLOTS = 10;
  localparam int DEPTH = 16;
  localparam int CX_W = 5;

  logic clk = 0;
  logic rst_n = 0;
  logic clear = 0;
  logic in_valid = 0;
  logic in_ready;
  logic [SLOTS-1:0] in_slot_vld = '0;
  logic [SLOTS*CX_W-1:0] in_cx = '0;
  logic [SLOTS-1:0] in_dec = '0;
  logic out_valid;
  logic out_ready = 0;
  logic [CX_W-1:0] out_cx;
  logic out_dec;

  int checks = 0;
  int errors = 0;
  int seq = 0;
  logic [5:0] mq [$];
  logic [15:0] lfsr = 16'hACE1;
  logic prev_hold = 0;
  logic [5:0] prev_out = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cxd_sequencer #(.SLOTS(SLOTS), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .clear(clear),
    .in_valid(in_valid), .in_ready(in_ready), .in_slot_vld(in_slot_vld),
    .in_cx(in_cx), .in_dec(in_dec),
    .out_valid(out_valid), .out_ready(out_ready), .out_cx(out_cx), .out_dec(out_dec)
  );

  task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_ports(input string req);
    logic exp_rdy;
    exp_rdy = (DEPTH - mq.size()) >= SLOTS;
    chk("R5 in_ready", {5'd0, in_ready}, {5'd0, exp_rdy});
    chk("R3 out_valid", {5'd0, out_valid}, {5'd0, logic'(mq.size() != 0)});
    if (mq.size() != 0) chk(req, {out_cx, out_dec}, mq[0]);
    if (prev_hold) chk("R4 payload hold", {out_cx, out_dec}, prev_out);
  endtask

  task automatic step(input logic v, input logic [SLOTS-1:0] m, input logic rdy,
                      input logic clr, input string req);
    logic acc, pop;
    logic [5:0] pr [SLOTS];
    for (int i = 0; i < SLOTS; i++) begin
      pr[i] = {5'((seq * 7 + i * 3) & 31), 1'((seq + i) & 1)};
      in_cx[i*CX_W +: CX_W] = pr[i][5:1];
      in_dec[i] = pr[i][0];
    end
    in_valid = v; in_slot_vld = m; out_ready = rdy; clear = clr;
    seq++;
    acc = v && in_ready;
    pop = out_valid && rdy;
    prev_hold = out_valid && !rdy && !clr;
    prev_out = {out_cx, out_dec};
    @(posedge clk);
    if (clr) mq.delete();
    else begin
      if (pop) void'(mq.pop_front());
      if (acc) for (int i = 0; i < SLOTS; i++) if (m[i]) mq.push_back(pr[i]);
    end
    @(negedge clk);
    check_ports(req);
  endtask

  function automatic logic nextbit();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk("R1 out_valid", {5'd0, out_valid}, 6'd0);
    chk("R1 in_ready", {5'd0, in_ready}, 6'd1);

    // R2 R3: every mask, output free-running
    for (int m = 0; m < 1024; m++) step(1'b1, 10'(m), 1'b1, 1'b0, "R2 compaction order");
    repeat (20) step(1'b0, '0, 1'b1, 1'b0, "R3 drain");

    // R6 R5 R4: full beat with stalled output, then beats while full
    step(1'b1, 10'h3FF, 1'b0, 1'b0, "R6 full beat stalled");
    for (int k = 0; k < 6; k++) step(1'b1, 10'h3FF, 1'b0, 1'b0, "R5 ignored while full");
    for (int k = 0; k < 6; k++) step(1'b1, 10'h155, 1'b0, 1'b0, "R4 stall");
    repeat (20) step(1'b0, '0, 1'b1, 1'b0, "R8 drain after stall");

    // R8 R9: every mask again, random ready, wraps storage
    for (int m = 0; m < 1024; m++) begin
      logic r;
      r = nextbit();
      step(1'b1, 10'(m ^ 10'h2A5), r, 1'b0, "R8 order with wrap");
      if (nextbit()) step(1'b0, '0, 1'b1, 1'b0, "R9 push pop mix");
    end

    // R7: clear with a simultaneous beat
    step(1'b1, 10'h0F0, 1'b0, 1'b0, "R7 prefill");
    step(1'b1, 10'h3FF, 1'b1, 1'b1, "R7 clear");
    chk("R7 empty after clear", {5'd0, out_valid}, 6'd0);
    step(1'b1, 10'h201, 1'b1, 1'b0, "R7 restart");
    repeat (5) step(1'b0, '0, 1'b1, 1'b0, "R7 drain");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule